// File: doc/BRIEF.md
# NAND Hamming ECC parity generator

This block computes a 24-bit single-error-correcting Hamming code over one NAND sector while the data passes on an 8-bit or 16-bit flash data bus. It watches bus transfers and folds each data byte into twelve parity pairs. Three pairs cover the bit position inside a byte (column parity). The remaining nine pairs cover the byte address inside the sector (line parity). Each pair has an odd term and an even term.

Software sets the sector length, the chip select to track, the bus width and the enable, and pulses clear before each sector. Parity is gathered only from data-phase transfers aimed at the tracked chip select. Once the programmed number of bytes has passed, a done flag rises and the result holds until the next clear. The result is available as a packed 32-bit word and as a 3-byte code for the spare area. The code is not inverted, so an erased sector of all-ones bytes yields a zero code, which does not match the all-ones spare bytes.

Top module: `nand_hamming_ecc`

## Requirements
- R1: The sector holds 2*(sz_half_m1+1) bytes. done is low until the transfer that carries the last byte of the sector. It is high from the cycle after that transfer onward.
- R2: Column pair j (j=0..2) uses the bit index i (0..7) inside each byte. The odd term is the XOR of all data bits whose index has bit j set. The even term is the XOR of all data bits whose index has bit j clear.
- R3: Line pair 3+k (k=0..8) uses the byte address a, counted from 0 at the first byte after clear. The odd term is the XOR of all bits of the bytes whose address has bit k set. The even term is the XOR of all bits of the bytes whose address has bit k clear.
- R4: In ecc_result, the even term of pair p (p=0..11) sits at bit p and the odd term sits at bit 16+p. Bits 15:12 and 31:28 are zero.
- R5: ecc_code[7:0] equals ecc_result[7:0] and ecc_code[15:8] equals ecc_result[23:16]. ecc_code[23:20] equals ecc_result[27:24] and ecc_code[19:16] equals ecc_result[11:8].
- R6: A transfer counts only when bus_valid, bus_data_phase and cfg_en are all high and bus_cs equals cfg_cs. Any other transfer leaves the result and the byte count unchanged.
- R7: With cfg_wide high, bus_data[7:0] is the byte at address a and bus_data[15:8] is the byte at a+1. Both bytes are taken in the same cycle. The result equals that of 8-bit mode on the same byte stream.
- R8: While done is high, transfers change neither ecc_result nor done.
- R9: A clear pulse sets ecc_result to zero, lowers done and restarts the byte address at 0. If a transfer arrives in the same cycle as the clear, the clear wins and the transfer is dropped.
- R10: The code is not inverted. A full sector of 0xFF bytes gives ecc_code = 0.
- R11: After reset, ecc_result is 0 and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Enable accumulation |
| cfg_cs | input | CS_W | Chip select to track |
| cfg_wide | input | 1 | 1: 16-bit bus, 0: 8-bit bus |
| cfg_sz_half_m1 | input | SZ_W | Sector byte count halved, minus one |
| clr | input | 1 | Clear the result, the count and done |
| bus_valid | input | 1 | A bus transfer occurs this cycle |
| bus_data_phase | input | 1 | 1: data cycle, 0: command or address cycle |
| bus_cs | input | CS_W | Chip select of the transfer |
| bus_data | input | 16 | Transfer data, low byte first |
| ecc_result | output | 32 | Packed even and odd parities |
| ecc_code | output | 24 | 3-byte code view |
| done | output | 1 | Sector fully consumed |

## Verification
The bench sweeps a single set bit through every position of a short sector. A wrong parity term or a swapped bit in the packing shows up there as a one-hot mismatch in the result or the code. Full-size sectors are run in both bus widths. A 16-bit path that gave the high byte the wrong address, or advanced the count by one, would give a different code or raise done late. Command cycles, a foreign chip select, a disabled engine and transfers after done are each placed in the middle of a sector. A design that let any of them through would corrupt the code or move done. The bench also checks a clear that collides with a transfer, and an erased sector. An inverted output would give an all-ones code for the erased sector instead of zero.

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc #(
  parameter int CS_W = 3,
  parameter int SZ_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic [CS_W-1:0] cfg_cs,
  input  logic            cfg_wide,
  input  logic [SZ_W-1:0] cfg_sz_half_m1,
  input  logic            clr,
  input  logic            bus_valid,
  input  logic            bus_data_phase,
  input  logic [CS_W-1:0] bus_cs,
  input  logic [15:0]     bus_data,
  output logic [31:0]     ecc_result,
  output logic [23:0]     ecc_code,
  output logic            done
);
  localparam int ADDR_W = SZ_W + 1;
  localparam int NPAIR  = 3 + ADDR_W;

  logic [31:0]     acc, acc_nxt;
  logic [ADDR_W:0] cnt, len, cnt_nxt;
  logic            take, last;

  assign take = cfg_en && bus_valid && bus_data_phase && (bus_cs == cfg_cs) && !done && !clr;
  assign len  = {1'b0, cfg_sz_half_m1, 1'b0} + (ADDR_W+1)'(2);
  assign cnt_nxt = cnt + (cfg_wide ? (ADDR_W+1)'(2) : (ADDR_W+1)'(1));
  assign last = cnt_nxt >= len;

  always_comb begin
    logic [7:0]        d;
    logic [ADDR_W-1:0] a;
    logic              pb;
    acc_nxt = acc;
    for (int b = 0; b < 2; b++) begin
      if (b == 0 || cfg_wide) begin
        d  = (b == 0) ? bus_data[7:0] : bus_data[15:8];
        a  = cnt[ADDR_W-1:0] + ADDR_W'(b);
        pb = ^d;
        for (int k = 0; k < 3; k++)
          for (int i = 0; i < 8; i++)
            if (((i >> k) & 1) == 1) acc_nxt[16+k] = acc_nxt[16+k] ^ d[i];
            else                     acc_nxt[k]    = acc_nxt[k]    ^ d[i];
        for (int k = 0; k < ADDR_W; k++)
          if (a[k]) acc_nxt[19+k] = acc_nxt[19+k] ^ pb;
          else      acc_nxt[3+k]  = acc_nxt[3+k]  ^ pb;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else if (clr) begin
      acc  <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else if (take) begin
      acc <= acc_nxt;
      cnt <= cnt_nxt;
      if (last) done <= 1'b1;
    end
  end

  assign ecc_result = acc;
  assign ecc_code   = {acc[27:24], acc[11:8], acc[23:16], acc[7:0]};

  p_frozen_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> ($stable(ecc_result) && done));
  p_ignored_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_data_phase && !clr) |=> ($stable(ecc_result) && $stable(cnt)));
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ecc_result == 32'd0 && !done && cnt == '0));
  p_wide_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cfg_wide) |=> (cnt == $past(cnt) + (ADDR_W+1)'(2)));
  p_unused_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_result[31:16+NPAIR] == '0 && ecc_result[15:NPAIR] == '0));
endmodule

// File: tb/test_nand_hamming_ecc.sv
module test_nand_hamming_ecc;
  logic        clk = 0, rst_n = 0;
  logic        cfg_en = 1, cfg_wide = 0, clr = 0;
  logic [2:0]  cfg_cs = 3'd2, bus_cs = 3'd2;
  logic [7:0]  cfg_sz_half_m1 = 8'd255;
  logic        bus_valid = 0, bus_data_phase = 1;
  logic [15:0] bus_data = 0;
  logic [31:0] ecc_result;
  logic [23:0] ecc_code;
  logic        done;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;
  logic [7:0] mem [512];

  always #2.5 clk = ~clk;

  nand_hamming_ecc i_nand_hamming_ecc (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cs(cfg_cs), .cfg_wide(cfg_wide),
    .cfg_sz_half_m1(cfg_sz_half_m1), .clr(clr), .bus_valid(bus_valid),
    .bus_data_phase(bus_data_phase), .bus_cs(bus_cs), .bus_data(bus_data),
    .ecc_result(ecc_result), .ecc_code(ecc_code), .done(done));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input int n);
    logic [31:0] r = 0;
    for (int a = 0; a < n; a++)
      for (int i = 0; i < 8; i++) begin
        for (int k = 0; k < 3; k++)
          if (((i >> k) & 1) == 1) r[16+k] ^= mem[a][i]; else r[k] ^= mem[a][i];
        for (int k = 0; k < 9; k++)
          if (((a >> k) & 1) == 1) r[19+k] ^= mem[a][i]; else r[3+k] ^= mem[a][i];
      end
    return r;
  endfunction

  function automatic logic [31:0] pack(input logic [31:0] r);
    return {8'd0, r[27:24], r[11:8], r[23:16], r[7:0]};
  endfunction

  task automatic xfer(input logic [15:0] d, input logic ph, input logic [2:0] c);
    bus_valid = 1; bus_data = d; bus_data_phase = ph; bus_cs = c;
    @(posedge clk); #1;
    bus_valid = 0; bus_data_phase = 1; bus_cs = cfg_cs;
  endtask

  task automatic do_clear();
    clr = 1; @(posedge clk); #1; clr = 0;
  endtask

  task automatic run(input int n, input logic wide);
    cfg_wide = wide;
    do_clear();
    if (wide) for (int i = 0; i < n/2; i++) xfer({mem[2*i+1], mem[2*i]}, 1, cfg_cs);
    else      for (int i = 0; i < n; i++)   xfer({8'h00, mem[i]}, 1, cfg_cs);
  endtask

  initial begin
    logic [31:0] exp, hold;
    #1;
    check("R11 reset result", ecc_result, 0);
    check("R11 reset done", {31'd0, done}, 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1;

    // R2 R3 R4 R5: single set bit swept over an 8-byte sector
    cfg_sz_half_m1 = 8'd3;
    for (int p = 0; p < 64; p++) begin
      for (int a = 0; a < 8; a++) mem[a] = 0;
      mem[p/8][p%8] = 1'b1;
      run(8, 0);
      exp = model(8);
      check("R2 R3 R4 sweep result", ecc_result, exp);
      check("R5 sweep code", {8'd0, ecc_code}, pack(exp));
    end

    // R1 R3: full sector 8-bit, done timing
    cfg_sz_half_m1 = 8'd255;
    for (int a = 0; a < 512; a++) mem[a] = 8'((a * 37 + 11) ^ (a >> 3) ^ (a * a));
    cfg_wide = 0;
    do_clear();
    for (int i = 0; i < 511; i++) xfer({8'h00, mem[i]}, 1, cfg_cs);
    check("R1 done low before last byte", {31'd0, done}, 0);
    xfer({8'h00, mem[511]}, 1, cfg_cs);
    check("R1 done after last byte", {31'd0, done}, 1);
    exp = model(512);
    check("R3 full 8-bit result", ecc_result, exp);

    // R8: transfer after done ignored
    xfer(16'h00FF, 1, cfg_cs);
    check("R8 result frozen", ecc_result, exp);
    check("R8 done stays", {31'd0, done}, 1);

    // R7: 16-bit mode same stream
    cfg_wide = 1;
    do_clear();
    for (int i = 0; i < 255; i++) xfer({mem[2*i+1], mem[2*i]}, 1, cfg_cs);
    check("R7 done low before last word", {31'd0, done}, 0);
    xfer({mem[511], mem[510]}, 1, cfg_cs);
    check("R7 done after last word", {31'd0, done}, 1);
    check("R7 wide result", ecc_result, exp);

    // R6: ignored transfers in mid-sector
    cfg_sz_half_m1 = 8'd3;
    cfg_wide = 0;
    do_clear();
    for (int i = 0; i < 3; i++) xfer({8'h00, mem[i]}, 1, cfg_cs);
    hold = ecc_result;
    xfer(16'h00A5, 0, cfg_cs);
    check("R6 command cycle ignored", ecc_result, hold);
    xfer(16'h00A5, 1, 3'd5);
    check("R6 foreign cs ignored", ecc_result, hold);
    cfg_en = 0;
    xfer(16'h00A5, 1, cfg_cs);
    cfg_en = 1;
    check("R6 disabled ignored", ecc_result, hold);
    for (int i = 3; i < 7; i++) xfer({8'h00, mem[i]}, 1, cfg_cs);
    check("R6 count unchanged, done low", {31'd0, done}, 0);
    xfer({8'h00, mem[7]}, 1, cfg_cs);
    check("R6 count unchanged, done high", {31'd0, done}, 1);
    check("R6 final result", ecc_result, model(8));

    // R9: clear colliding with transfer
    clr = 1;
    xfer(16'h00C3, 1, cfg_cs);
    clr = 0;
    check("R9 clear result", ecc_result, 0);
    check("R9 clear done", {31'd0, done}, 0);
    for (int i = 0; i < 8; i++) xfer({8'h00, mem[i]}, 1, cfg_cs);
    check("R9 address restarted", ecc_result, model(8));
    check("R9 done after restart", {31'd0, done}, 1);

    // R10: erased sector
    cfg_sz_half_m1 = 8'd255;
    for (int a = 0; a < 512; a++) mem[a] = 8'hFF;
    run(512, 1);
    check("R10 erased code zero", {8'd0, ecc_code}, 0);
    check("R10 erased done", {31'd0, done}, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule